// File: doc/BRIEF.md
# Multi-Mode GPIO Pin Controller

This block controls eight general-purpose pins through a small memory-mapped register set. Each pin has a 2-bit drive mode: push-pull output, input, open-drain or open-source. Software picks the level a pin drives in one of two ways. It can use a software output latch, which has atomic set, clear and toggle strobes. Or it can hand the pin to one of eight peripheral signals, chosen per pin by a 3-bit source select. A per-pin input-buffer enable gates the readback of the sampled pin level. The incoming level passes through a two-flop synchronizer.

Each pin is presented to the pad ring as three signals: a level, an output enable and an input-buffer enable. Pull resistors and analog routing sit outside the block. The register interface is a single-cycle bus: writes take effect on the clock edge, and reads return one cycle later.

Top module: `gpio_drive_ctrl`

## Requirements
- R1: After reset every register holds 0, `pad_oe` is all ones, `pad_out` is all zeros, `pad_ie` is all zeros and `bus_rdata` is 0.
- R2: The mode word at byte address 0x00 holds pin n's mode in bits [2n+1:2n]. Code 00 is push-pull, which sets `pad_oe[n]`=1 and `pad_out[n]` to the pin's drive value.
- R3: Mode code 01 is input. The pin is never driven: `pad_oe[n]`=0 and `pad_out[n]`=0.
- R4: Mode code 10 is open-drain. A drive value of 0 gives `pad_oe[n]`=1 with `pad_out[n]`=0. A drive value of 1 releases the pin (`pad_oe[n]`=0). `pad_out[n]` stays 0 in both cases.
- R5: Mode code 11 is open-source. A drive value of 1 gives `pad_oe[n]`=1 with `pad_out[n]`=1. A drive value of 0 releases the pin (`pad_oe[n]`=0). `pad_out[n]` stays 1 in both cases.
- R6: Source-enable register bit n is at 0x08, and the source select for pin n is at 0x20+4n, bits [2:0]. When the source-enable bit is 0, the drive value is bit n of the latch at 0x0C. When it is 1, the drive value is `periph_src[select]`.
- R7: Writing to 0x14, 0x18 or 0x1C sets, clears or inverts every latch bit whose write-data bit is 1. Bits written as 0 are unchanged. All three addresses read as 0.
- R8: The input-enable register is at 0x04, and bit n drives `pad_ie[n]`. Data-in at 0x10 returns `pad_in` after a two-flop synchronizer, ANDed with the input-enable bits. With the address held, a `pad_in` change shows in `bus_rdata` at the third rising edge. Writes to 0x10 have no effect.
- R9: The alias at 0x40 maps bits [7:0] onto the mode fields of pins 0 to 3. The alias at 0x44 maps bits [7:0] onto pins 4 to 7. Both share storage with 0x00.
- R10: Misaligned addresses and word addresses above 0x44 read as 0 and ignore writes.
- R11: `bus_rdata` is registered and presents the value of the addressed register one cycle after the address. Bits above a register's width read as 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bus_addr | input | 7 | Byte address |
| bus_wr | input | 1 | Write strobe |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Registered read data |
| periph_src | input | 8 | Peripheral drive signals, indexed by the source select |
| pad_in | input | 8 | Pin levels from the pads |
| pad_out | output | 8 | Level presented to each pad |
| pad_oe | output | 8 | Output enable per pad |
| pad_ie | output | 8 | Input-buffer enable per pad |

## Verification
The pins are first placed in a mixed configuration: two pins in each mode, with a latch pattern that gives every mode both drive values. One pass therefore separates all four mode encodings and both polarities of the release rules. A second pass runs several peripheral bit patterns through distinct per-pin selects. It mixes latch-sourced and peripheral-sourced pins, which exposes a wrong select index or a swapped source choice. The atomic strobes use overlapping masks, so set, clear and toggle each leave some bits untouched. Aliased half-words, the synchronizer latency and unmapped or read-only writes are checked through readback.

// File: rtl/gpio_drive_pkg.sv
`timescale 1ns/1ps
package gpio_drive_pkg;
    typedef enum logic [1:0] {
        MODE_PUSH   = 2'b00,
        MODE_INPUT  = 2'b01,
        MODE_DRAIN  = 2'b10,
        MODE_SOURCE = 2'b11
    } pin_mode_e;

    // Word indices (byte address / 4)
    localparam int IDX_MODE = 0;
    localparam int IDX_IEN  = 1;
    localparam int IDX_SRCE = 2;
    localparam int IDX_LAT  = 3;
    localparam int IDX_DIN  = 4;
    localparam int IDX_SET  = 5;
    localparam int IDX_CLR  = 6;
    localparam int IDX_TGL  = 7;
    localparam int IDX_SEL0 = 8;
    localparam int IDX_MLO  = 16;
    localparam int IDX_MHI  = 17;
endpackage

// File: rtl/gpio_in_sync.sv
`timescale 1ns/1ps
module gpio_in_sync #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] async_in,
    output logic [W-1:0] sync_out
);
    logic [W-1:0] meta_q, stable_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            meta_q   <= '0;
            stable_q <= '0;
        end else begin
            meta_q   <= async_in;
            stable_q <= meta_q;
        end
    end

    assign sync_out = stable_q;
endmodule

// File: rtl/gpio_pin_drive.sv
`timescale 1ns/1ps
module gpio_pin_drive
    import gpio_drive_pkg::*;
#(
    parameter int NSRC  = 8,
    parameter int SEL_W = 3
) (
    input  logic [1:0]       mode,
    input  logic             latch,
    input  logic             use_src,
    input  logic [SEL_W-1:0] sel,
    input  logic [NSRC-1:0]  src,
    input  logic             ien,
    output logic             out,
    output logic             oe,
    output logic             ie
);
    logic level;

    always_comb begin
        level = use_src ? src[sel] : latch;
        unique case (pin_mode_e'(mode))
            MODE_PUSH:   begin oe = 1'b1;   out = level; end
            MODE_INPUT:  begin oe = 1'b0;   out = 1'b0;  end
            MODE_DRAIN:  begin oe = ~level; out = 1'b0;  end
            MODE_SOURCE: begin oe = level;  out = 1'b1;  end
            default:     begin oe = 1'b0;   out = 1'b0;  end
        endcase
    end

    assign ie = ien;
endmodule

// File: rtl/gpio_drive_regs.sv
`timescale 1ns/1ps
module gpio_drive_regs
    import gpio_drive_pkg::*;
#(
    parameter int NPIN   = 8,
    parameter int NSRC   = 8,
    parameter int ADDR_W = 7,
    parameter int DATA_W = 32
) (
    input  logic                        clk,
    input  logic                        rst_n,
    input  logic [ADDR_W-1:0]           bus_addr,
    input  logic                        bus_wr,
    input  logic [DATA_W-1:0]           bus_wdata,
    input  logic [NPIN-1:0]             pad_sync,
    output logic [DATA_W-1:0]           bus_rdata,
    output logic [2*NPIN-1:0]           mode,
    output logic [NPIN-1:0]             ien,
    output logic [NPIN-1:0]             srce,
    output logic [NPIN-1:0]             latch,
    output logic [NPIN*$clog2(NSRC)-1:0] sel
);
    localparam int SEL_W  = $clog2(NSRC);
    localparam int MODE_W = 2 * NPIN;
    localparam int HALF_W = MODE_W / 2;

    typedef struct packed {
        logic [MODE_W-1:0]     mode;
        logic [NPIN-1:0]       ien;
        logic [NPIN-1:0]       srce;
        logic [NPIN-1:0]       latch;
        logic [NPIN*SEL_W-1:0] sel;
        logic [DATA_W-1:0]     rdata;
    } regs_t;

    regs_t st_d, st_q;
    logic  aligned;
    int    widx;
    logic [NPIN-1:0] wbits;

    assign aligned = (bus_addr[1:0] == 2'b00);
    assign widx    = int'(bus_addr[ADDR_W-1:2]);
    assign wbits   = bus_wdata[NPIN-1:0];

    always_comb begin
        logic [DATA_W-1:0] rd;
        st_d = st_q;
        rd   = '0;
        if (bus_wr && aligned) begin
            case (widx)
                IDX_MODE: st_d.mode  = bus_wdata[MODE_W-1:0];
                IDX_IEN:  st_d.ien   = wbits;
                IDX_SRCE: st_d.srce  = wbits;
                IDX_LAT:  st_d.latch = wbits;
                IDX_SET:  st_d.latch = st_q.latch | wbits;
                IDX_CLR:  st_d.latch = st_q.latch & ~wbits;
                IDX_TGL:  st_d.latch = st_q.latch ^ wbits;
                IDX_MLO:  st_d.mode[HALF_W-1:0]      = bus_wdata[HALF_W-1:0];
                IDX_MHI:  st_d.mode[MODE_W-1:HALF_W] = bus_wdata[HALF_W-1:0];
                default: ;
            endcase
            for (int p = 0; p < NPIN; p++) begin
                if (widx == IDX_SEL0 + p)
                    st_d.sel[p*SEL_W +: SEL_W] = bus_wdata[SEL_W-1:0];
            end
        end
        if (aligned) begin
            case (widx)
                IDX_MODE: rd = DATA_W'(st_q.mode);
                IDX_IEN:  rd = DATA_W'(st_q.ien);
                IDX_SRCE: rd = DATA_W'(st_q.srce);
                IDX_LAT:  rd = DATA_W'(st_q.latch);
                IDX_DIN:  rd = DATA_W'(pad_sync & st_q.ien);
                IDX_MLO:  rd = DATA_W'(st_q.mode[HALF_W-1:0]);
                IDX_MHI:  rd = DATA_W'(st_q.mode[MODE_W-1:HALF_W]);
                default:  rd = '0;
            endcase
            for (int p = 0; p < NPIN; p++) begin
                if (widx == IDX_SEL0 + p)
                    rd = DATA_W'(st_q.sel[p*SEL_W +: SEL_W]);
            end
        end
        st_d.rdata = rd;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign bus_rdata = st_q.rdata;
    assign mode      = st_q.mode;
    assign ien       = st_q.ien;
    assign srce      = st_q.srce;
    assign latch     = st_q.latch;
    assign sel       = st_q.sel;

    logic unused_wdata;
    assign unused_wdata = ^bus_wdata[DATA_W-1:MODE_W];
endmodule

// File: rtl/gpio_drive_ctrl.sv
`timescale 1ns/1ps
module gpio_drive_ctrl #(
    parameter int NPIN   = 8,
    parameter int NSRC   = 8,
    parameter int ADDR_W = 7,
    parameter int DATA_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic              bus_wr,
    input  logic [DATA_W-1:0] bus_wdata,
    output logic [DATA_W-1:0] bus_rdata,
    input  logic [NSRC-1:0]   periph_src,
    input  logic [NPIN-1:0]   pad_in,
    output logic [NPIN-1:0]   pad_out,
    output logic [NPIN-1:0]   pad_oe,
    output logic [NPIN-1:0]   pad_ie
);
    localparam int SEL_W = $clog2(NSRC);

    logic [2*NPIN-1:0]     mode_w;
    logic [NPIN-1:0]       ien_w, srce_w, latch_w, sync_w;
    logic [NPIN*SEL_W-1:0] sel_w;

    gpio_in_sync #(.W(NPIN)) u_sync (
        .clk(clk), .rst_n(rst_n), .async_in(pad_in), .sync_out(sync_w)
    );

    gpio_drive_regs #(.NPIN(NPIN), .NSRC(NSRC), .ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_regs (
        .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wr(bus_wr),
        .bus_wdata(bus_wdata), .pad_sync(sync_w), .bus_rdata(bus_rdata),
        .mode(mode_w), .ien(ien_w), .srce(srce_w), .latch(latch_w), .sel(sel_w)
    );

    for (genvar p = 0; p < NPIN; p++) begin : g_pin
        gpio_pin_drive #(.NSRC(NSRC), .SEL_W(SEL_W)) u_drv (
            .mode(mode_w[2*p +: 2]), .latch(latch_w[p]), .use_src(srce_w[p]),
            .sel(sel_w[p*SEL_W +: SEL_W]), .src(periph_src), .ien(ien_w[p]),
            .out(pad_out[p]), .oe(pad_oe[p]), .ie(pad_ie[p])
        );
    end
endmodule

// File: rtl/gpio_drive_chk.sv
`timescale 1ns/1ps
module gpio_drive_chk
    import gpio_drive_pkg::*;
#(
    parameter int NPIN   = 8,
    parameter int ADDR_W = 7,
    parameter int DATA_W = 32
) (
    input logic              clk,
    input logic              rst_n,
    input logic [ADDR_W-1:0] bus_addr,
    input logic              bus_wr,
    input logic [DATA_W-1:0] bus_wdata,
    input logic [DATA_W-1:0] bus_rdata,
    input logic [NPIN-1:0]   pad_out,
    input logic [NPIN-1:0]   pad_oe,
    input logic [2*NPIN-1:0] mode_w,
    input logic [NPIN-1:0]   latch_w
);
    logic unmapped, is_set, is_clr;
    logic [NPIN-1:0] wb;
    assign unmapped = (bus_addr[1:0] != 2'b00) || (int'(bus_addr[ADDR_W-1:2]) > IDX_MHI);
    assign is_set   = bus_wr && (bus_addr == ADDR_W'(IDX_SET * 4));
    assign is_clr   = bus_wr && (bus_addr == ADDR_W'(IDX_CLR * 4));
    assign wb       = bus_wdata[NPIN-1:0];

    for (genvar p = 0; p < NPIN; p++) begin : g_chk
        a_r2_push_drives: assert property (@(posedge clk) disable iff (!rst_n)
            (mode_w[2*p +: 2] == MODE_PUSH) |-> pad_oe[p]);
        a_r3_input_released: assert property (@(posedge clk) disable iff (!rst_n)
            (mode_w[2*p +: 2] == MODE_INPUT) |-> !pad_oe[p]);
        a_r4_drain_low_only: assert property (@(posedge clk) disable iff (!rst_n)
            (mode_w[2*p +: 2] == MODE_DRAIN && pad_oe[p]) |-> !pad_out[p]);
        a_r5_source_high_only: assert property (@(posedge clk) disable iff (!rst_n)
            (mode_w[2*p +: 2] == MODE_SOURCE && pad_oe[p]) |-> pad_out[p]);
    end

    a_r7_set_bits: assert property (@(posedge clk) disable iff (!rst_n)
        is_set |=> ((latch_w & $past(wb)) == $past(wb)));
    a_r7_clr_bits: assert property (@(posedge clk) disable iff (!rst_n)
        is_clr |=> ((latch_w & $past(wb)) == '0));
    a_r10_unmapped_zero: assert property (@(posedge clk) disable iff (!rst_n)
        unmapped |=> (bus_rdata == '0));

    logic unused_w;
    assign unused_w = ^bus_wdata[DATA_W-1:NPIN];
endmodule

bind gpio_drive_ctrl gpio_drive_chk #(.NPIN(NPIN), .ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_chk (
    .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wr(bus_wr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .pad_out(pad_out),
    .pad_oe(pad_oe), .mode_w(mode_w), .latch_w(latch_w)
);

// File: tb/tb_gpio_drive_ctrl.sv
`timescale 1ns/1ps
module tb_gpio_drive_ctrl;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [6:0]  bus_addr = '0;
    logic        bus_wr = 1'b0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic [7:0]  periph_src = '0;
    logic [7:0]  pad_in = '0;
    logic [7:0]  pad_out, pad_oe, pad_ie;

    int n_checks = 0, n_fail = 0;
    bit done = 1'b0;

    // bench shadow of configuration
    logic [15:0] s_mode = '0;
    logic [7:0]  s_lat = '0, s_srce = '0;
    logic [23:0] s_sel = '0;

    always #2.5 clk = ~clk;

    gpio_drive_ctrl dut (
        .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wr(bus_wr),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .periph_src(periph_src),
        .pad_in(pad_in), .pad_out(pad_out), .pad_oe(pad_oe), .pad_ie(pad_ie)
    );

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic wr(input int a, input logic [31:0] d);
        @(negedge clk);
        bus_addr = 7'(a); bus_wr = 1'b1; bus_wdata = d;
        @(negedge clk);
        bus_wr = 1'b0;
    endtask

    task automatic rd(input int a, output logic [31:0] d);
        @(negedge clk);
        bus_addr = 7'(a); bus_wr = 1'b0;
        @(negedge clk);
        d = bus_rdata;
    endtask

    // expected {oe, out} from the requirements R2-R6
    function automatic logic [15:0] model();
        logic [7:0] oe, out;
        for (int p = 0; p < 8; p++) begin
            logic v;
            v = s_srce[p] ? periph_src[s_sel[3*p +: 3]] : s_lat[p];
            case (s_mode[2*p +: 2])
                2'b00: begin oe[p] = 1'b1; out[p] = v;    end
                2'b01: begin oe[p] = 1'b0; out[p] = 1'b0; end
                2'b10: begin oe[p] = ~v;   out[p] = 1'b0; end
                default: begin oe[p] = v;  out[p] = 1'b1; end
            endcase
        end
        return {oe, out};
    endfunction

    task automatic t_reset();
        logic [31:0] r;
        check("R1 rdata", bus_rdata, 0);
        check("R1 pads", {8'h0, pad_oe, pad_out, pad_ie}, {8'h0, 8'hFF, 8'h00, 8'h00});
        rd(32'h00, r); check("R1 mode", r, 0);
        rd(32'h0C, r); check("R1 latch", r, 0);
    endtask

    task automatic t_push_pull();
        logic [31:0] r;
        wr(32'h0C, 32'hFFFF_FFA5); s_lat = 8'hA5;
        check("R2 push-pull pads", {16'h0, pad_oe, pad_out}, {16'h0, model()});
        rd(32'h0C, r); check("R11 latch upper bits zero", r, 32'h0000_00A5);
    endtask

    task automatic t_strobes();
        logic [31:0] r;
        wr(32'h14, 32'h0F); check("R7 set", {24'h0, pad_out}, 32'hAF);
        wr(32'h18, 32'h21); check("R7 clear", {24'h0, pad_out}, 32'h8E);
        wr(32'h1C, 32'hF0); check("R7 toggle", {24'h0, pad_out}, 32'h7E);
        s_lat = 8'h7E;
        rd(32'h14, r); check("R7 set reads 0", r, 0);
        rd(32'h18, r); check("R7 clear reads 0", r, 0);
        rd(32'h1C, r); check("R7 toggle reads 0", r, 0);
    endtask

    task automatic t_modes();
        // pins0,1 input; 2,3 open-drain; 4,5 open-source; 6,7 push-pull
        wr(32'h00, 32'h0FA5); s_mode = 16'h0FA5;
        wr(32'h0C, 32'h5A);   s_lat = 8'h5A;
        check("R3 R4 R5 mixed modes", {16'h0, pad_oe, pad_out}, {16'h0, model()});
        check("R4 R5 mixed modes literal", {16'h0, pad_oe, pad_out}, {16'h0, 8'hD4, 8'h70});
        wr(32'h0C, 32'hA5);   s_lat = 8'hA5;
        check("R3 R4 R5 inverted latch", {16'h0, pad_oe, pad_out}, {16'h0, model()});
    endtask

    task automatic t_alias();
        logic [31:0] r;
        wr(32'h40, 32'hFFFF_FF3C);
        wr(32'h44, 32'h0000_00C1); s_mode = 16'hC13C;
        rd(32'h00, r); check("R9 alias into main", r, 32'hC13C);
        rd(32'h40, r); check("R9 low alias read", r, 32'h3C);
        rd(32'h44, r); check("R9 high alias read", r, 32'hC1);
        check("R9 pads follow alias", {16'h0, pad_oe, pad_out}, {16'h0, model()});
        wr(32'h00, 32'h0); s_mode = 16'h0;
    endtask

    task automatic t_periph();
        logic [31:0] r;
        logic [7:0] pats [4] = '{8'hA5, 8'h3C, 8'h01, 8'h80};
        for (int p = 0; p < 8; p++) begin
            wr(32'h20 + 4 * p, 32'((3 * p + 1) % 8));
            s_sel[3*p +: 3] = 3'((3 * p + 1) % 8);
        end
        rd(32'h24, r); check("R6 select readback", r, 32'h4);
        wr(32'h08, 32'hFF); s_srce = 8'hFF;
        for (int i = 0; i < 4; i++) begin
            periph_src = pats[i];
            #1;
            check("R6 peripheral drive", {16'h0, pad_oe, pad_out}, {16'h0, model()});
        end
        wr(32'h08, 32'h0F); s_srce = 8'h0F;
        periph_src = 8'h96; #1;
        check("R6 mixed sources", {16'h0, pad_oe, pad_out}, {16'h0, model()});
        wr(32'h00, 32'hE4E4); s_mode = 16'hE4E4;
        check("R6 peripheral with modes", {16'h0, pad_oe, pad_out}, {16'h0, model()});
        wr(32'h00, 32'h0); s_mode = 16'h0;
        wr(32'h08, 32'h0); s_srce = 8'h0;
    endtask

    task automatic t_din();
        logic [31:0] r;
        wr(32'h04, 32'h0F);
        check("R8 input enable pin", {24'h0, pad_ie}, 32'h0F);
        @(negedge clk); pad_in = 8'hFF; bus_addr = 7'h10;
        @(negedge clk); check("R8 sync edge1", bus_rdata, 0);
        @(negedge clk); check("R8 sync edge2", bus_rdata, 0);
        @(negedge clk); check("R8 sync edge3 gated", bus_rdata, 32'h0F);
        wr(32'h10, 32'hFF);
        rd(32'h10, r); check("R8 din write ignored", r, 32'h0F);
        wr(32'h04, 32'h00);
        rd(32'h10, r); check("R8 disabled reads 0", r, 0);
        check("R8 ie off", {24'h0, pad_ie}, 0);
    endtask

    task automatic t_unmapped();
        logic [31:0] r;
        wr(32'h48, 32'hFFFF_FFFF);
        wr(32'h0D, 32'hFFFF_FFFF);
        wr(32'h7C, 32'hFFFF_FFFF);
        rd(32'h0C, r); check("R10 latch unchanged", r, {24'h0, s_lat});
        rd(32'h00, r); check("R10 mode unchanged", r, 0);
        rd(32'h48, r); check("R10 unmapped read", r, 0);
        rd(32'h0D, r); check("R10 misaligned read", r, 0);
        check("R10 pads unchanged", {16'h0, pad_oe, pad_out}, {16'h0, model()});
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        t_reset();
        t_push_pull();
        t_strobes();
        t_modes();
        t_alias();
        t_periph();
        t_din();
        t_unmapped();
        if (!done) begin
            done = 1'b1;
            $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
            $finish;
        end
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            done = 1'b1;
            n_checks++; n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
            $finish;
        end
    end
endmodule